// File: doc/BRIEF.md
# Test Control Register Unit

This unit holds the levels that steer a chip's functional test mode: a test-mode enable, a clock-stop level for a processor core the test does not need, a level that keeps that core in reset, and the width used to load program code from the pads. A tester reaches it through a small register port, typically bridged from a JTAG data register. The unit does not gate clocks or sequence the TAP itself. It only drives the control levels, and each of them comes straight from a flop.

The control fields are protected. They accept writes only after two 32-bit keys have been written, in order, to the key register. A key state machine tracks this with three states: `ST_LOCKED`, `ST_KEY1_OK` and `ST_UNLOCKED`. It has these transitions:
- `LOCKED->KEY1_OK` on the first key.
- `KEY1_OK->UNLOCKED` on the second key.
- `KEY1_OK->LOCKED` on any other key value.
- `LOCKED->LOCKED` on a wrong key.
- `UNLOCKED->LOCKED` on any key write.
- A forced return to `ST_LOCKED` while the functional or delayed reset is active.

State falls into two reset classes. The download width and a sticky early-write flag are cleared only by power-on reset, so they survive the functional resets issued between repeated pattern runs. Everything else, including the lock, returns to zero on each functional reset.

A delayed reset input keeps the functional-class state cleared after the rest of the logic has been released. Any write that arrives while this reset is low is dropped and sets the sticky flag. This lets a failing pattern show that its keys were sent too early.

Top module: `test_ctrl_regs`

## Requirements
- R1: After power-on reset, every control output is 0, `dl_width` is 2'b00, the unit is locked, and both CTRL (address 1) and STATUS (address 2) read 0.
- R2: A write of KEY_FIRST to address 0 followed by a write of KEY_SECOND to address 0 sets `unlocked` at the clock edge of the second write. STATUS bit 0 reads 1 from then on.
- R3: A wrong key value at either step returns the sequence to its start, and KEY_SECOND on its own never unlocks the unit.
- R4: While the unit is locked, writes to CTRL have no effect on CTRL or on the control outputs.
- R5: While the unit is unlocked, a write to CTRL loads the outputs at that write's clock edge. Bit 0 drives `test_mode_en`, bit 1 drives `core_clk_gate_en` (1 = core clock stopped), bit 2 drives `core_rst_hold`, and bits 5:4 drive `dl_width`.
- R6: `dl_width` encodes 2'b00 = 16-bit, 2'b01 = 8-bit and 2'b10 = 1-bit download. A written value of 2'b11 leaves the field at its previous value, while the other CTRL bits of the same write still take effect.
- R7: A functional reset clears `test_mode_en`, `core_clk_gate_en` and `core_rst_hold`, and relocks the unit. It leaves `dl_width` unchanged.
- R8: While `dly_rst_n` is low, all writes are dropped, the functional-class outputs and the lock are held cleared, and each dropped write sets STATUS bit 1.
- R9: STATUS bit 1, once set, stays set through functional and delayed resets until the next power-on reset.
- R10: Any write to the key register while the unit is unlocked locks it again and leaves the control outputs unchanged.
- R11: Address 0 and all addresses above 2 read as 0. CTRL reads back bits 0, 1, 2 and 5:4 as defined in R5, and STATUS reads `unlocked` in bit 0 and the early-write flag in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| func_rst_n | input | 1 | Functional reset, synchronous, active low |
| dly_rst_n | input | 1 | Delayed reset for this unit, synchronous, active low |
| acc_wr | input | 1 | Write strobe of the access port |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data for `acc_addr`, combinational |
| test_mode_en | output | 1 | Functional test mode enable |
| core_clk_gate_en | output | 1 | 1 stops the unused core's clock, registered |
| core_rst_hold | output | 1 | 1 holds the unused core in reset |
| dl_width | output | 2 | Code download width select |
| unlocked | output | 1 | Protected fields are writable |

## Verification
The bench writes both keys while the delayed reset is still low. If a design accepted those writes, it would unlock early and leave the sticky flag clear. The bench also interrupts the key sequence with a wrong value and then sends only the second key; a design that kept partial progress would unlock at that point. A functional reset is pulsed after the download width has been changed. A design that put the width in the functional class would read back 16-bit, and one that put the flag there would lose the evidence of the early write. The reserved width code is also written, which exposes a design that latches 2'b11 or drops the other bits of the same write.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

    // Key sequence states
    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY1_OK  = 2'd1,
        ST_UNLOCKED = 2'd2
    } key_state_e;

    // Register addresses
    localparam int ADDR_KEY    = 0;
    localparam int ADDR_CTRL   = 1;
    localparam int ADDR_STATUS = 2;

    // CTRL field positions
    localparam int CTRL_TM_BIT   = 0;
    localparam int CTRL_GATE_BIT = 1;
    localparam int CTRL_HOLD_BIT = 2;
    localparam int CTRL_DL_LSB   = 4;
    localparam int DL_W          = 2;

    // STATUS field positions
    localparam int STAT_UNLOCK_BIT = 0;
    localparam int STAT_EARLY_BIT  = 1;

    // Download width codes
    localparam logic [DL_W-1:0] DL_16   = 2'b00;
    localparam logic [DL_W-1:0] DL_8    = 2'b01;
    localparam logic [DL_W-1:0] DL_1    = 2'b10;
    localparam logic [DL_W-1:0] DL_RSVD = 2'b11;

    // Functional-reset class controls
    typedef struct packed {
        logic test_mode;
        logic clk_gate;
        logic rst_hold;
    } run_ctrl_t;

endpackage

// File: rtl/tcr_key_fsm.sv
module tcr_key_fsm
    import tcr_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h5A5A_0F0F,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hA5A5_F0F0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              clr,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              unlocked
);

    key_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_LOCKED;
        end else if (key_wr) begin
            unique case (state_q)
                ST_LOCKED:   state_d = (key_data == KEY_FIRST)  ? ST_KEY1_OK  : ST_LOCKED;
                ST_KEY1_OK:  state_d = (key_data == KEY_SECOND) ? ST_UNLOCKED : ST_LOCKED;
                ST_UNLOCKED: state_d = ST_LOCKED;
                default:     state_d = ST_LOCKED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unlocked = (state_q == ST_UNLOCKED);
    end

endmodule

// File: rtl/tcr_ctrl_regs.sv
module tcr_ctrl_regs
    import tcr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              clr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output run_ctrl_t         run_q,
    output logic [DL_W-1:0]   dl_q
);

    logic [DL_W-1:0] dl_new;
    assign dl_new = wdata[CTRL_DL_LSB +: DL_W];

    // Functional-reset class: cleared by POR, functional or delayed reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_q <= '0;
        end else if (clr) begin
            run_q <= '0;
        end else if (ctrl_wr) begin
            run_q.test_mode <= wdata[CTRL_TM_BIT];
            run_q.clk_gate  <= wdata[CTRL_GATE_BIT];
            run_q.rst_hold  <= wdata[CTRL_HOLD_BIT];
        end
    end

    // Power-on class: retained across functional resets
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            dl_q <= DL_16;
        end else if (ctrl_wr && (dl_new != DL_RSVD)) begin
            dl_q <= dl_new;
        end
    end

endmodule

// File: rtl/tcr_early_flag.sv
module tcr_early_flag (
    input  logic clk,
    input  logic por_n,
    input  logic early_wr,
    output logic flag_q
);

    // Sticky, power-on class only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (early_wr) begin
            flag_q <= 1'b1;
        end
    end

endmodule

// File: rtl/test_ctrl_regs.sv
module test_ctrl_regs
    import tcr_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h5A5A_0F0F,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hA5A5_F0F0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              func_rst_n,
    input  logic              dly_rst_n,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              test_mode_en,
    output logic              core_clk_gate_en,
    output logic              core_rst_hold,
    output logic [1:0]        dl_width,
    output logic              unlocked
);

    localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(ADDR_KEY);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);

    logic            clr;
    logic            wr_ok;
    logic            key_wr;
    logic            ctrl_wr;
    logic            early_wr;
    logic            early_flag;
    logic            unlocked_i;
    run_ctrl_t       run_q;
    logic [DL_W-1:0] dl_q;

    // Write qualification
    assign clr      = !func_rst_n || !dly_rst_n;
    assign wr_ok    = acc_wr && !clr;
    assign early_wr = acc_wr && !dly_rst_n;
    assign key_wr   = wr_ok && (acc_addr == A_KEY);
    assign ctrl_wr  = wr_ok && (acc_addr == A_CTRL) && unlocked_i;

    tcr_key_fsm #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (clr),
        .key_wr  (key_wr),
        .key_data(acc_wdata),
        .unlocked(unlocked_i)
    );

    tcr_ctrl_regs #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (clr),
        .ctrl_wr(ctrl_wr),
        .wdata  (acc_wdata),
        .run_q  (run_q),
        .dl_q   (dl_q)
    );

    tcr_early_flag u_flag (
        .clk     (clk),
        .por_n   (por_n),
        .early_wr(early_wr),
        .flag_q  (early_flag)
    );

    // Read mux
    always_comb begin
        acc_rdata = '0;
        if (acc_addr == A_CTRL) begin
            acc_rdata[CTRL_TM_BIT]              = run_q.test_mode;
            acc_rdata[CTRL_GATE_BIT]            = run_q.clk_gate;
            acc_rdata[CTRL_HOLD_BIT]            = run_q.rst_hold;
            acc_rdata[CTRL_DL_LSB +: DL_W]      = dl_q;
        end else if (acc_addr == A_STATUS) begin
            acc_rdata[STAT_UNLOCK_BIT]          = unlocked_i;
            acc_rdata[STAT_EARLY_BIT]           = early_flag;
        end
    end

    // Control levels straight from flops
    assign test_mode_en     = run_q.test_mode;
    assign core_clk_gate_en = run_q.clk_gate;
    assign core_rst_hold    = run_q.rst_hold;
    assign dl_width         = dl_q;
    assign unlocked         = unlocked_i;

endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hA5A5_F0F0
) (
    input logic              clk,
    input logic              por_n,
    input logic              func_rst_n,
    input logic              dly_rst_n,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              test_mode_en,
    input logic              core_clk_gate_en,
    input logic              core_rst_hold,
    input logic [1:0]        dl_width,
    input logic              unlocked,
    input logic [DATA_W-1:0] acc_rdata
);

    // R2: unlocking follows a second-key write
    a_r2_unlock_after_second_key: assert property (@(posedge clk) disable iff (!por_n)
        $rose(unlocked) |-> $past(acc_wr && (acc_addr == '0) && (acc_wdata == KEY_SECOND)));

    // R4: locked unit keeps its controls
    a_r4_locked_ctrl_stable: assert property (@(posedge clk) disable iff (!por_n)
        (!unlocked && func_rst_n && dly_rst_n) |=>
            ($stable(test_mode_en) && $stable(core_clk_gate_en) &&
             $stable(core_rst_hold) && $stable(dl_width)));

    // R6: reserved width code never reaches the output
    a_r6_no_reserved_width: assert property (@(posedge clk) disable iff (!por_n)
        dl_width != 2'b11);

    // R7: functional reset clears run controls and the lock
    a_r7_func_clears: assert property (@(posedge clk) disable iff (!por_n)
        !func_rst_n |=> (!unlocked && !test_mode_en && !core_clk_gate_en && !core_rst_hold));

    // R7: functional reset keeps the download width
    a_r7_width_kept: assert property (@(posedge clk) disable iff (!por_n)
        !func_rst_n |=> $stable(dl_width));

    // R8: delayed reset holds the functional class cleared
    a_r8_dly_holds_clear: assert property (@(posedge clk) disable iff (!por_n)
        !dly_rst_n |=> (!unlocked && !test_mode_en && !core_clk_gate_en && !core_rst_hold));

    // R8: dropped write raises the early flag
    a_r8_early_flag_set: assert property (@(posedge clk) disable iff (!por_n)
        (!dly_rst_n && acc_wr) |=> (acc_rdata[1] || (acc_addr != 4'd2)));

    // R9: early flag remains once set
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        ((acc_addr == 4'd2) && acc_rdata[1]) |=> (acc_rdata[1] || (acc_addr != 4'd2)));

endmodule

bind test_ctrl_regs tcr_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk             (clk),
    .por_n           (por_n),
    .func_rst_n      (func_rst_n),
    .dly_rst_n       (dly_rst_n),
    .acc_wr          (acc_wr),
    .acc_addr        (acc_addr),
    .acc_wdata       (acc_wdata),
    .test_mode_en    (test_mode_en),
    .core_clk_gate_en(core_clk_gate_en),
    .core_rst_hold   (core_rst_hold),
    .dl_width        (dl_width),
    .unlocked        (unlocked),
    .acc_rdata       (acc_rdata)
);

// File: tb/test_ctrl_regs_tb.sv
module test_ctrl_regs_tb;

    localparam logic [31:0] K1 = 32'h5A5A_0F0F;
    localparam logic [31:0] K2 = 32'hA5A5_F0F0;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        func_rst_n = 1'b1;
    logic        dly_rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        test_mode_en, core_clk_gate_en, core_rst_hold, unlocked;
    logic [1:0]  dl_width;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        rd_ev;

    always #5 clk = ~clk;

    test_ctrl_regs u_dut (
        .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n), .dly_rst_n(dly_rst_n),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .test_mode_en(test_mode_en),
        .core_clk_gate_en(core_clk_gate_en), .core_rst_hold(core_rst_hold),
        .dl_width(dl_width), .unlocked(unlocked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected read data and compares
    initial begin
        forever begin
            @(rd_ev);
            #1;
            chk(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        acc_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ->rd_ev;
        #2;
    endtask

    task automatic outs(input string tag, input logic [4:0] e);
        chk(tag, {27'd0, test_mode_en, core_clk_gate_en, core_rst_hold, dl_width}, {27'd0, e});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        outs("R1 outputs", 5'b000_00);
        chk("R1 unlocked", {31'd0, unlocked}, 32'd0);
        rd(4'd1, 32'h0, "R1 CTRL");
        rd(4'd2, 32'h0, "R1 STATUS");

        // R8 writes during delayed reset are dropped and flagged
        wr(4'd0, K1);
        wr(4'd0, K2);
        chk("R8 still locked", {31'd0, unlocked}, 32'd0);
        rd(4'd2, 32'h2, "R8 STATUS flag");
        @(negedge clk); dly_rst_n = 1'b1;
        @(negedge clk);
        rd(4'd2, 32'h2, "R9 flag after dly release");

        // R4 locked CTRL write ignored
        wr(4'd1, 32'h17);
        rd(4'd1, 32'h0, "R4 CTRL locked");
        outs("R4 outputs locked", 5'b000_00);

        // R3 broken sequences
        wr(4'd0, K2);
        chk("R3 second key alone", {31'd0, unlocked}, 32'd0);
        wr(4'd0, K1);
        wr(4'd0, 32'h1234_5678);
        wr(4'd0, K2);
        rd(4'd2, 32'h2, "R3 wrong key restarts");

        // R2 correct sequence
        wr(4'd0, K1);
        chk("R2 one key not enough", {31'd0, unlocked}, 32'd0);
        wr(4'd0, K2);
        chk("R2 unlocked", {31'd0, unlocked}, 32'd1);
        rd(4'd2, 32'h3, "R2 STATUS");

        // R5 control fields
        wr(4'd1, 32'h17);
        rd(4'd1, 32'h17, "R5 CTRL readback");
        outs("R5 outputs", 5'b111_01);

        // R6 width encodings and reserved code
        wr(4'd1, 32'h31);
        rd(4'd1, 32'h11, "R6 reserved width kept");
        outs("R6 other bits applied", 5'b100_01);
        wr(4'd1, 32'h20);
        outs("R6 one-bit width", 5'b000_10);
        wr(4'd1, 32'h02);
        outs("R6 sixteen-bit width", 5'b010_00);
        wr(4'd1, 32'h13);
        rd(4'd1, 32'h13, "R6 eight-bit width");

        // R7 functional reset
        @(negedge clk); func_rst_n = 1'b0;
        @(negedge clk); func_rst_n = 1'b1;
        rd(4'd1, 32'h10, "R7 width kept, run bits cleared");
        outs("R7 outputs", 5'b000_01);
        rd(4'd2, 32'h2, "R7 relocked and R9 flag kept");

        // R10 key write while unlocked relocks
        wr(4'd0, K1);
        wr(4'd0, K2);
        wr(4'd1, 32'h06);
        wr(4'd0, K1);
        chk("R10 relocked", {31'd0, unlocked}, 32'd0);
        outs("R10 outputs unchanged", 5'b011_00);

        // R11 unused addresses
        rd(4'd0, 32'h0, "R11 key reads zero");
        rd(4'd5, 32'h0, "R11 unmapped reads zero");

        // R8 delayed reset holds functional class clear
        wr(4'd0, K2);
        wr(4'd0, K1);
        wr(4'd0, K2);
        wr(4'd1, 32'h17);
        @(negedge clk); dly_rst_n = 1'b0;
        @(negedge clk);
        outs("R8 held cleared", 5'b000_01);
        chk("R8 held locked", {31'd0, unlocked}, 32'd0);
        @(negedge clk); dly_rst_n = 1'b1;
        @(negedge clk);

        // R1 and R9: a new power-on reset clears everything
        por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        rd(4'd2, 32'h0, "R9 POR clears flag");
        rd(4'd1, 32'h0, "R1 POR clears width");

        @(negedge clk);
        finish_run();
    end

endmodule